// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block compares square-wave phase signals and produces two independent error outputs, one for each detector type. The level detector marks the cycles in which its reference and the shared feedback signal disagree. The edge detector is a set/reset flag: a falling edge of the feedback signal sets it, and a falling edge of a second reference signal clears it. Each error output is meant to steer the count direction of a loop counter in an all-digital phase-locked loop.

All three phase inputs may be asynchronous to the system clock. Each one passes through a synchronizer chain of `SYNC_STAGES` flops. Edges are found by comparing the newest synchronized sample with the sample taken one clock earlier. Both outputs come from registers.

At zero phase error the two detectors settle at different points. The level detector is centred when its inputs are a quarter period apart, which gives a gain of 4. The edge detector is centred when its inputs are half a period apart, which gives a gain of 2. At either of those offsets the output is a square wave with 50% duty. At the edges of the linear range the output stays high or stays low without switching.

Top module: `dual_phase_det`

## Requirements
- R1: `xor_err_o` is 1 when the settled levels of `ref_xor_i` and `fb_i` differ, and 0 when they are equal.
- R2: A falling edge on `fb_i` sets `edge_err_o` to 1, whether `ref_edge_i` is high or low.
- R3: A falling edge on `ref_edge_i` clears `edge_err_o` to 0, whether `fb_i` is high or low.
- R4: Rising edges on `fb_i` or `ref_edge_i` leave `edge_err_o` unchanged.
- R5: When `fb_i` and `ref_edge_i` fall in the same sampled clock, `edge_err_o` keeps its previous value.
- R6: While `rst` is 1 at a rising clock edge, both outputs become 0 on that edge and stay 0. After `rst` is released, inputs that are already high are taken as rising edges, so `edge_err_o` remains 0.
- R7: A change on a phase input reaches the outputs at the rising edge `SYNC_STAGES`+1 after the change is applied, which is the 3rd edge with the default setting. The outputs do not change at any earlier edge.
- R8: With a 16-cycle period on every input, `fb_i` lagging `ref_xor_i` by 4 cycles and `ref_edge_i` lagging `fb_i` by 8 cycles, each output is high for exactly 32 of any 64 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock. All phase inputs are sampled on its rising edge. |
| rst | input | 1 | Synchronous reset, active high. |
| ref_xor_i | input | 1 | Reference phase for the level (exclusive-OR) detector. |
| fb_i | input | 1 | Feedback phase, shared by both detectors. |
| ref_edge_i | input | 1 | Reference phase for the edge detector. Its falling edge clears the flag. |
| xor_err_o | output | 1 | Error output of the level detector. |
| edge_err_o | output | 1 | Error output of the edge detector, a set/reset flag. |

## Verification
The hardest case to produce is a falling edge on both edge-detector inputs in the same sampled clock, while the flag is in a known state. Ordinary phase offsets rarely line these up. The stimulus table therefore first puts the flag at 0 and then at 1 with ordinary single-input edges. It then drives both inputs from high to low at the same clock, so that both edges go through identical synchronizer chains and arrive together. The duty-cycle test uses free-running waveforms with fixed lags and counts high cycles only after a warm-up window, so the check does not depend on the starting state.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    // One sample of all three phase inputs.
    typedef struct packed {
        logic ref_x;
        logic fb;
        logic ref_e;
    } phase_t;

    localparam int PHASE_W = $bits(phase_t);

    // Falling-edge indications used by the edge detector.
    typedef struct packed {
        logic fb_fall;
        logic re_fall;
    } falls_t;

    typedef enum logic [1:0] {
        EC_HOLD  = 2'd0,
        EC_SET   = 2'd1,
        EC_CLEAR = 2'd2
    } ec_act_t;

    function automatic falls_t find_falls(phase_t prev, phase_t cur);
        falls_t f;
        f.fb_fall = prev.fb    & ~cur.fb;
        f.re_fall = prev.ref_e & ~cur.ref_e;
        return f;
    endfunction

    // Feedback fall sets, reference fall clears, coincident falls hold.
    function automatic ec_act_t ec_decide(falls_t f);
        if (f.fb_fall && !f.re_fall) return EC_SET;
        if (f.re_fall && !f.fb_fall) return EC_CLEAR;
        return EC_HOLD;
    endfunction

endpackage

// File: rtl/dpd_sync.sv
module dpd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[LAST];
endmodule

// File: rtl/dpd_edge_track.sv
module dpd_edge_track
    import dpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t cur_i,
    output phase_t prev_o,
    output falls_t falls_o
);
    phase_t prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= cur_i;
    end

    assign prev_o  = prev_q;
    assign falls_o = find_falls(prev_q, cur_i);
endmodule

// File: rtl/dpd_xor_det.sv
module dpd_xor_det
    import dpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t cur_i,
    output logic   err_o
);
    logic err_q;

    always_ff @(posedge clk) begin
        if (rst) err_q <= 1'b0;
        else     err_q <= cur_i.ref_x ^ cur_i.fb;
    end

    assign err_o = err_q;
endmodule

// File: rtl/dpd_edge_det.sv
module dpd_edge_det
    import dpd_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  falls_t falls_i,
    output logic   err_o
);
    ec_act_t act;
    logic    flag_q;

    assign act = ec_decide(falls_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            unique case (act)
                EC_SET:   flag_q <= 1'b1;
                EC_CLEAR: flag_q <= 1'b0;
                default:  flag_q <= flag_q;
            endcase
        end
    end

    assign err_o = flag_q;
endmodule

// File: rtl/dual_phase_det.sv
module dual_phase_det
    import dpd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_xor_i,
    input  logic fb_i,
    input  logic ref_edge_i,
    output logic xor_err_o,
    output logic edge_err_o
);
    phase_t raw;
    phase_t samp_cur;
    phase_t samp_prev;
    falls_t falls;

    assign raw.ref_x = ref_xor_i;
    assign raw.fb    = fb_i;
    assign raw.ref_e = ref_edge_i;

    generate
        if (SYNC_STAGES > 0) begin : g_sync
            dpd_sync #(
                .WIDTH (PHASE_W),
                .STAGES(SYNC_STAGES)
            ) u_sync (
                .clk(clk),
                .rst(rst),
                .d_i(raw),
                .q_o(samp_cur)
            );
        end else begin : g_nosync
            assign samp_cur = raw;
        end
    endgenerate

    dpd_edge_track u_track (
        .clk    (clk),
        .rst    (rst),
        .cur_i  (samp_cur),
        .prev_o (samp_prev),
        .falls_o(falls)
    );

    dpd_xor_det u_xor (
        .clk  (clk),
        .rst  (rst),
        .cur_i(samp_cur),
        .err_o(xor_err_o)
    );

    dpd_edge_det u_edge (
        .clk    (clk),
        .rst    (rst),
        .falls_i(falls),
        .err_o  (edge_err_o)
    );
endmodule

// File: rtl/dpd_checker.sv
module dpd_checker
    import dpd_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input phase_t cur,
    input phase_t prev,
    input logic   xor_err,
    input logic   edge_err
);
    logic fbf, ref_f;
    assign fbf   = prev.fb & ~cur.fb;
    assign ref_f = prev.ref_e & ~cur.ref_e;

    // R6
    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!xor_err && !edge_err));

    // R1
    a_r1_xor_follows: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (xor_err == $past(cur.ref_x != cur.fb)));

    // R2
    a_r2_fb_fall_sets: assert property (@(posedge clk) disable iff (rst)
        (fbf && !ref_f) |=> edge_err);

    // R3
    a_r3_ref_fall_clears: assert property (@(posedge clk) disable iff (rst)
        (ref_f && !fbf) |=> !edge_err);

    // R4
    a_r4_no_fall_holds: assert property (@(posedge clk) disable iff (rst)
        (!fbf && !ref_f) |=> $stable(edge_err));

    // R5
    a_r5_both_fall_holds: assert property (@(posedge clk) disable iff (rst)
        (fbf && ref_f) |=> $stable(edge_err));
endmodule

bind dual_phase_det dpd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cur     (samp_cur),
    .prev    (samp_prev),
    .xor_err (xor_err_o),
    .edge_err(edge_err_o)
);

// File: tb/tb_dual_phase_det.sv
module tb_dual_phase_det;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 17;

    // Entry bits: {ref_xor, fb, ref_edge, expected xor_err, expected edge_err}
    localparam logic [4:0] VEC [NVEC] = '{
        5'b000_00, // R1 all low
        5'b010_10, // R4 fb rises
        5'b011_10, // R4 ref_edge rises
        5'b001_01, // R2 fb falls, ref_edge high
        5'b101_11, // R1
        5'b100_10, // R3 ref_edge falls, fb low
        5'b110_00, // R4 fb rises
        5'b100_11, // R2 fb falls, ref_edge low
        5'b001_01, // R4 ref_edge rises
        5'b011_11, // R4 fb rises
        5'b010_10, // R3 ref_edge falls, fb high
        5'b111_00, // R1
        5'b100_10, // R5 both fall, flag low
        5'b011_10, // R4
        5'b001_01, // R2
        5'b011_11, // R4
        5'b000_01  // R5 both fall, flag high
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_xor_i = 1'b0;
    logic fb_i = 1'b0;
    logic ref_edge_i = 1'b0;
    logic xor_err_o, edge_err_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_phase_det #(.SYNC_STAGES(2)) dut (
        .clk       (clk),
        .rst       (rst),
        .ref_xor_i (ref_xor_i),
        .fb_i      (fb_i),
        .ref_edge_i(ref_edge_i),
        .xor_err_o (xor_err_o),
        .edge_err_o(edge_err_o)
    );

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(logic rx, logic fb, logic re);
        ref_xor_i  = rx;
        fb_i       = fb;
        ref_edge_i = re;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R6 reset xor", xor_err_o, 0);
        check("R6 reset edge", edge_err_o, 0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            drive(VEC[i][4], VEC[i][3], VEC[i][2]);
            repeat (4) @(negedge clk);
            check($sformatf("R1 vec%0d xor", i), xor_err_o, VEC[i][1]);
            check($sformatf("R2/R3/R4/R5 vec%0d edge", i), edge_err_o, VEC[i][0]);
        end

        // R7: latency of SYNC_STAGES+1 edges (state 000, flag 1)
        @(negedge clk); drive(0, 0, 1);
        repeat (4) @(negedge clk);
        drive(1, 0, 0);
        @(negedge clk);
        check("R7 edge after 1", edge_err_o, 1);
        check("R7 xor after 1", xor_err_o, 0);
        @(negedge clk);
        check("R7 edge after 2", edge_err_o, 1);
        check("R7 xor after 2", xor_err_o, 0);
        @(negedge clk);
        check("R7 edge after 3", edge_err_o, 0);
        check("R7 xor after 3", xor_err_o, 1);

        // R8: zero-error offsets give 50% duty
        begin
            int hx = 0;
            int he = 0;
            for (int t = 0; t < 128; t++) begin
                if (t >= 64) begin
                    hx += int'(xor_err_o);
                    he += int'(edge_err_o);
                end
                drive(((t % 16) < 8), (((t + 12) % 16) < 8), (((t + 4) % 16) < 8));
                @(negedge clk);
            end
            check("R8 xor duty", hx, 32);
            check("R8 edge duty", he, 32);
        end

        // R6: reset in mid operation
        drive(1, 1, 0);
        repeat (4) @(negedge clk);
        drive(1, 0, 0);
        repeat (4) @(negedge clk);
        check("R6 pre xor", xor_err_o, 1);
        check("R6 pre edge", edge_err_o, 1);
        rst = 1'b1;
        @(negedge clk);
        check("R6 mid xor", xor_err_o, 0);
        check("R6 mid edge", edge_err_o, 0);
        repeat (3) @(negedge clk);
        check("R6 held xor", xor_err_o, 0);
        check("R6 held edge", edge_err_o, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        check("R6 release xor", xor_err_o, 1);
        check("R6 release edge", edge_err_o, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule